// File: doc/BRIEF.md
# Serial EEPROM command sequencer

This block is a SPI-mode master that runs complete command frames against an external serial EEPROM. A host raises a one-cycle request carrying an operation select, a memory address, a byte count and up to `MAX_BYTES` bytes of write data. The sequencer then drives chip select, serial clock and serial output, and collects the serial input. Every frame is an 8-bit command byte, then an address field of `ADDR_BITS` bits when the command needs one, then the data bytes. Everything is sent most significant bit first, in clock mode 0.

Operations that change the device (array write and status write) need extra frames, and the sequencer adds them itself. It first sends a one-byte write-enable frame. It then sends the operation frame. After that it keeps reading the status register until the write-in-progress flag (status bit 0) is clear, and only then reports completion. After reset the sequencer stays silent and not ready until a power-up wake interval has passed. The interval is set in microseconds and converted to clock cycles from the clock frequency parameter.

Top module: `spi_eeprom_seq`

## Requirements
- R1: After reset `ready_o` is low, `cs_no` is high and `sck_o` is low. No frame starts and requests are ignored until `CLK_HZ/1e6*WAKE_US` cycles have elapsed, after which `ready_o` goes high.
- R2: Clock mode 0. `sck_o` idles low, each high phase of `sck_o` lasts exactly `CLK_DIV` cycles, `mosi_o` changes only while `sck_o` is low, and `miso_i` is sampled at the rising edge.
- R3: `cs_no` stays low for a whole frame and stays high for at least `CLK_DIV` cycles between frames. `sck_o` is low whenever `cs_no` is high.
- R4: A frame is the command byte, then for read and write the address (`ADDR_BITS` = 8, 16 or 24 bits), then the data bytes, all MSB first.
- R5: The `op_i` codes map to command bytes as follows: 0 write-enable 0x06, 1 write-disable 0x04, 2 read-status 0x05, 3 write-status 0x01, 4 read 0x03, 5 write 0x02. Codes 6 and 7 are ignored: no frame and no `done_o`.
- R6: A write or write-status request first sends a one-byte 0x06 frame, releases `cs_no`, then sends the operation frame.
- R7: After a write or write-status frame the block repeats 2-byte read-status frames while the returned bit 0 is 1. It asserts `done_o` only after a status with bit 0 = 0.
- R8: Read and write move `len_i+1` data bytes. Write sends `wdata_i[7:0]` first. Read stores the first byte received in `rdata_o[7:0]`, the next in `[15:8]`, and so on. `rdata_o` is cleared when a read or read-status request is accepted.
- R9: Read-status returns the device status byte in `rdata_o[7:0]`. Write-status sends `wdata_i[7:0]` as its data byte.
- R10: `done_o` is a one-cycle pulse at the end of each accepted request. `ready_o` is low from acceptance until `done_o`.
- R11: Requests made while a request is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken when `ready_o` is high |
| op_i | input | 3 | Operation select (R5) |
| addr_i | input | ADDR_BITS | Memory address |
| len_i | input | $clog2(MAX_BYTES) | Data byte count minus one |
| wdata_i | input | 8*MAX_BYTES | Write data, byte 0 sent first |
| ready_o | output | 1 | Awake and idle |
| done_o | output | 1 | Request complete pulse |
| rdata_o | output | 8*MAX_BYTES | Read data or status |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the memory |
| cs_no | output | 1 | Active-low chip select |
| miso_i | input | 1 | Serial data from the memory |

## Verification
Faults in the byte index or the frame kind show up within one frame. They appear as a wrong bit count between edges of `cs_no`, a wrong command byte, or a missing write-enable frame in front of a write. A fault in the status capture shows up as a wrong number of polling frames or as a `done_o` that comes early. A faulty wake counter shows up as a chip-select edge or an early `ready_o` within the first few hundred cycles after reset. Read-path faults land in `rdata_o` at the `done_o` of the same request, including stale bytes left over from a longer earlier read.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    OP_WREN  = 3'd0,
    OP_WRDI  = 3'd1,
    OP_RDSR  = 3'd2,
    OP_WRSR  = 3'd3,
    OP_READ  = 3'd4,
    OP_WRITE = 3'd5
  } op_e;

  typedef enum logic [1:0] {FR_WEN, FR_MAIN, FR_POLL} frame_e;

  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_WRDI  = 8'h04;
  localparam logic [7:0] CMD_RDSR  = 8'h05;
  localparam logic [7:0] CMD_WRSR  = 8'h01;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_WRITE = 8'h02;

  function automatic logic [7:0] cmd_of(op_e op);
    case (op)
      OP_WREN:  return CMD_WREN;
      OP_WRDI:  return CMD_WRDI;
      OP_RDSR:  return CMD_RDSR;
      OP_WRSR:  return CMD_WRSR;
      OP_READ:  return CMD_READ;
      default:  return CMD_WRITE;
    endcase
  endfunction

  function automatic logic is_mod(op_e op);
    return (op == OP_WRITE) || (op == OP_WRSR);
  endfunction
endpackage

// File: rtl/eep_wake_timer.sv
module eep_wake_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic woke_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      woke_o <= 1'b0;
    end else if (!woke_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(CYCLES - 1)) woke_o <= 1'b1;
    end
  end
endmodule

// File: rtl/eep_shift_engine.sv
module eep_shift_engine #(
  parameter int unsigned DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int unsigned DW = $clog2(DIV + 1);

  logic [DW-1:0] div_q;
  logic [3:0]    half_q;
  logic [7:0]    tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      sck_o  <= 1'b0;
      div_q  <= '0;
      half_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          tx_q   <= tx_i;
          div_q  <= '0;
          half_q <= '0;
          sck_o  <= 1'b0;
        end
      end else if (div_q == DW'(DIV - 1)) begin
        div_q  <= '0;
        half_q <= half_q + 1'b1;
        if (!sck_o) begin
          sck_o <= 1'b1;
          rx_q  <= {rx_q[6:0], miso_i};  // sample at rising edge
        end else begin
          sck_o <= 1'b0;
          if (half_q == 4'd15) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            tx_q <= {tx_q[6:0], 1'b0};   // next bit while clock low
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign mosi_o = tx_q[7];
  assign rx_o   = rx_q;

  a_r2_mosi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));
  a_r2_sck_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sck_o);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq
  import eep_pkg::*;
#(
  parameter int unsigned ADDR_BITS = 16,
  parameter int unsigned MAX_BYTES = 4,
  parameter int unsigned CLK_DIV   = 2,
  parameter int unsigned CLK_HZ    = 250_000_000,
  parameter int unsigned WAKE_US   = 2100,
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [2:0]             op_i,
  input  logic [ADDR_BITS-1:0]   addr_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [8*MAX_BYTES-1:0] wdata_i,
  output logic                   ready_o,
  output logic                   done_o,
  output logic [8*MAX_BYTES-1:0] rdata_o,
  output logic                   sck_o,
  output logic                   mosi_o,
  output logic                   cs_no,
  input  logic                   miso_i
);
  localparam int unsigned WAKE_CYCLES = CLK_HZ / 1_000_000 * WAKE_US;
  localparam int unsigned AB = ADDR_BITS / 8;
  localparam int unsigned IW = $clog2(AB + MAX_BYTES + 2);
  localparam int unsigned GW = $clog2(CLK_DIV + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_e;

  st_e                  st_q;
  op_e                  op_q;
  frame_e               frame_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic [LEN_W-1:0]     len_q;
  logic [8*MAX_BYTES-1:0] wdata_q, rdata_q;
  logic [IW-1:0]        idx_q, flen;
  logic [GW-1:0]        gap_q;
  logic [7:0]           stat_q, tx_byte, eng_rx;
  logic                 kick_q, cs_q, done_q, woke, eng_busy, eng_done, has_addr;
  int                   data_idx;

  eep_wake_timer #(.CYCLES(WAKE_CYCLES)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .woke_o(woke)
  );

  eep_shift_engine #(.DIV(CLK_DIV)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(kick_q), .tx_i(tx_byte),
    .busy_o(eng_busy), .done_o(eng_done), .rx_o(eng_rx),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  assign has_addr = (frame_q == FR_MAIN) && (op_q == OP_READ || op_q == OP_WRITE);
  assign data_idx = int'(idx_q) - 1 - (has_addr ? int'(AB) : 0);

  always_comb begin
    case (frame_q)
      FR_WEN:  flen = IW'(1);
      FR_POLL: flen = IW'(2);
      default: begin
        case (op_q)
          OP_READ, OP_WRITE: flen = IW'(2 + AB) + IW'(len_q);
          OP_RDSR, OP_WRSR:  flen = IW'(2);
          default:           flen = IW'(1);
        endcase
      end
    endcase
  end

  always_comb begin
    tx_byte = 8'h00;
    if (idx_q == '0) begin
      case (frame_q)
        FR_WEN:  tx_byte = CMD_WREN;
        FR_POLL: tx_byte = CMD_RDSR;
        default: tx_byte = cmd_of(op_q);
      endcase
    end else if (has_addr && int'(idx_q) <= int'(AB)) begin
      tx_byte = 8'(addr_q >> (8 * (int'(AB) - int'(idx_q))));
    end else if (frame_q == FR_MAIN && is_mod(op_q)) begin
      for (int k = 0; k < int'(MAX_BYTES); k++)
        if (data_idx == k) tx_byte = wdata_q[8*k +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      op_q    <= OP_WREN;
      frame_q <= FR_MAIN;
      addr_q  <= '0;
      len_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      idx_q   <= '0;
      gap_q   <= '0;
      stat_q  <= '0;
      kick_q  <= 1'b0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      kick_q <= 1'b0;
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (woke && req_i && op_i <= 3'd5) begin
            op_q    <= op_e'(op_i);
            addr_q  <= addr_i;
            len_q   <= len_i;
            wdata_q <= wdata_i;
            if (op_e'(op_i) == OP_READ || op_e'(op_i) == OP_RDSR) rdata_q <= '0;
            frame_q <= is_mod(op_e'(op_i)) ? FR_WEN : FR_MAIN;
            idx_q   <= '0;
            cs_q    <= 1'b0;
            kick_q  <= 1'b1;
            st_q    <= S_RUN;
          end
        end
        S_RUN: begin
          if (eng_done) begin
            if (frame_q == FR_POLL && idx_q == IW'(1)) stat_q <= eng_rx;
            if (frame_q == FR_MAIN && op_q == OP_RDSR && idx_q == IW'(1))
              rdata_q[7:0] <= eng_rx;
            if (frame_q == FR_MAIN && op_q == OP_READ)
              for (int k = 0; k < int'(MAX_BYTES); k++)
                if (data_idx == k) rdata_q[8*k +: 8] <= eng_rx;
            if (idx_q == flen - 1'b1) begin
              cs_q  <= 1'b1;
              gap_q <= '0;
              st_q  <= S_GAP;
            end else begin
              idx_q  <= idx_q + 1'b1;
              kick_q <= 1'b1;
            end
          end
        end
        default: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GW'(CLK_DIV - 1)) begin
            idx_q <= '0;
            if (frame_q == FR_WEN ||
                (frame_q == FR_MAIN && is_mod(op_q)) ||
                (frame_q == FR_POLL && stat_q[0])) begin
              frame_q <= (frame_q == FR_WEN) ? FR_MAIN : FR_POLL;
              cs_q    <= 1'b0;
              kick_q  <= 1'b1;
              st_q    <= S_RUN;
            end else begin
              done_q <= 1'b1;
              st_q   <= S_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign cs_no   = cs_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign ready_o = woke && (st_q == S_IDLE);

  a_r1_quiet_until_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !woke |-> (cs_no && !ready_o));
  a_r3_sck_low_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
  a_r3_start_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_q |-> !cs_no);
  a_r7_done_after_idle_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_mod(op_q)) |-> !stat_q[0]);
  a_r10_not_ready_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !ready_o);
endmodule

// File: tb/sim_spi_eeprom_seq.sv
module sim_spi_eeprom_seq;
  localparam int AB_BITS = 16;
  localparam int NB = 4;
  localparam int DIV = 2;
  localparam int WAKE = 300;   // 1 MHz * 300 us
  localparam int BUSY_POLLS = 2;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [2:0] op = '0;
  logic [AB_BITS-1:0] addr = '0;
  logic [1:0] len = '0;
  logic [8*NB-1:0] wdata = '0, rdata;
  logic ready, done, sck, mosi, cs_n;
  logic miso = 1'b0;

  always #2 clk = ~clk;

  spi_eeprom_seq #(.ADDR_BITS(AB_BITS), .MAX_BYTES(NB), .CLK_DIV(DIV),
                   .CLK_HZ(1_000_000), .WAKE_US(WAKE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .len_i(len), .wdata_i(wdata), .ready_o(ready), .done_o(done),
    .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi), .cs_no(cs_n), .miso_i(miso));

  // ---------------- memory model ----------------
  logic [7:0] mem [256];
  logic [7:0] sr = 8'h00, shin = 8'h00, opc = 8'h00, outb = 8'h00, ap = 8'h00;
  logic [15:0] aacc = '0, last_addr = '0;
  logic wel = 1'b0, wel0 = 1'b0;
  int wip_left = 0, bitc = 0, nfr = 0, cs_falls = 0;
  logic [7:0] fr_op [16];
  int fr_bits [16];
  int cyc_n = 0, cs_rise_t = 0, min_gap = 1000, sck_rise_t = 0, hi_min = 1000, hi_max = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
  always @(negedge clk) cyc_n++;

  task automatic model_byte(input int n);
    if (n == 1) begin
      opc = shin;
      if (opc == 8'h05) outb = {sr[7:2], wel, wip_left > 0};
    end else if ((opc == 8'h03 || opc == 8'h02) && n <= 3) begin
      aacc = {aacc[7:0], shin};
      if (n == 3) begin
        last_addr = aacc;
        ap = aacc[7:0];
        if (opc == 8'h03) begin outb = mem[ap]; ap++; end
      end
    end else if (opc == 8'h03) begin
      outb = mem[ap]; ap++;
    end else if (opc == 8'h02 && wel0) begin
      mem[ap] = shin; ap++;
    end else if (opc == 8'h01 && n == 2 && wel0) begin
      sr[7:2] = shin[7:2];
    end
  endtask

  always @(negedge cs_n) begin
    bitc = 0; outb = 8'h00; miso = 1'b0; wel0 = wel; cs_falls++;
    min_gap = (cyc_n - cs_rise_t < min_gap) ? cyc_n - cs_rise_t : min_gap;
  end
  always @(posedge sck) if (!cs_n) begin
    sck_rise_t = cyc_n;
    shin = {shin[6:0], mosi};
    bitc++;
    if (bitc % 8 == 0) model_byte(bitc / 8);
  end
  always @(negedge sck) if (!cs_n) begin
    if (cyc_n - sck_rise_t < hi_min) hi_min = cyc_n - sck_rise_t;
    if (cyc_n - sck_rise_t > hi_max) hi_max = cyc_n - sck_rise_t;
    miso = outb[7];
    outb = {outb[6:0], 1'b0};
  end
  always @(posedge cs_n) if (bitc > 0) begin
    cs_rise_t = cyc_n;
    if (nfr < 16) begin fr_op[nfr] = opc; fr_bits[nfr] = bitc; end
    nfr++;
    case (opc)
      8'h06: wel = 1'b1;
      8'h04: wel = 1'b0;
      8'h05: if (wip_left > 0) wip_left--;
      8'h01, 8'h02: if (wel0) begin wel = 1'b0; wip_left = BUSY_POLLS; end
      default: ;
    endcase
    bitc = 0;
  end

  // ---------------- checking ----------------
  int checks = 0, failures = 0;
  bit fin = 1'b0;

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cmd(input logic [2:0] o);
    case (o)
      3'd0: return 8'h06;
      3'd1: return 8'h04;
      3'd2: return 8'h05;
      3'd3: return 8'h01;
      3'd4: return 8'h03;
      default: return 8'h02;
    endcase
  endfunction

  task automatic issue(input logic [2:0] o, input logic [15:0] a, input logic [1:0] l,
                       input logic [31:0] wd);
    int t;
    t = 0;
    while (!ready && t < 5000) begin @(negedge clk); t++; end
    nfr = 0;
    op = o; addr = a; len = l; wdata = wd; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk("R10", "done seen", done, 1'b1);
    @(negedge clk);
    chk("R10", "done one cycle", done, 1'b0);
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] addr;
    logic [1:0]  len;
    logic [31:0] wdata;
    logic        chk_rd;
    logic [31:0] exp_rd;
    logic [7:0]  exp_frames;
    logic [7:0]  exp_bits;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd5, 16'h0123, 2'd3, 32'hDDCCBBAA, 1'b0, 32'h0,        8'd5, 8'd56},
    '{3'd4, 16'h0123, 2'd3, 32'h0,        1'b1, 32'hDDCCBBAA, 8'd1, 8'd56},
    '{3'd4, 16'h0124, 2'd1, 32'h0,        1'b1, 32'h0000CCBB, 8'd1, 8'd40},
    '{3'd3, 16'h0000, 2'd0, 32'h0000008C, 1'b0, 32'h0,        8'd5, 8'd16},
    '{3'd2, 16'h0000, 2'd0, 32'h0,        1'b1, 32'h0000008C, 8'd1, 8'd16},
    '{3'd0, 16'h0000, 2'd0, 32'h0,        1'b0, 32'h0,        8'd1, 8'd8},
    '{3'd2, 16'h0000, 2'd0, 32'h0,        1'b1, 32'h0000008E, 8'd1, 8'd16},
    '{3'd1, 16'h0000, 2'd0, 32'h0,        1'b0, 32'h0,        8'd1, 8'd8},
    '{3'd2, 16'h0000, 2'd0, 32'h0,        1'b1, 32'h0000008C, 8'd1, 8'd16},
    '{3'd5, 16'h5A3C, 2'd0, 32'h00000077, 1'b0, 32'h0,        8'd5, 8'd32},
    '{3'd4, 16'h5A3C, 2'd0, 32'h0,        1'b1, 32'h00000077, 8'd1, 8'd32}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1", "cs_n in reset", cs_n, 1'b1);
    chk("R1", "sck in reset", sck, 1'b0);
    chk("R1", "ready in reset", ready, 1'b0);
    chk("R1", "done in reset", done, 1'b0);
    rst_n = 1'b1;
    // R1 request during wake is ignored
    repeat (100) @(negedge clk);
    op = 3'd4; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (149) @(negedge clk);
    chk("R1", "ready before wake", ready, 1'b0);
    repeat (70) @(negedge clk);
    chk("R1", "ready after wake", ready, 1'b1);
    chk("R1", "no frame from early request", cs_falls, 0);

    // R5 illegal op codes
    issue(3'd6, 16'h0, 2'd0, 32'h0);
    repeat (100) @(negedge clk);
    chk("R5", "op 6 makes no frame", cs_falls, 0);
    chk("R5", "op 6 keeps ready", ready, 1'b1);

    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      issue(v.op, v.addr, v.len, v.wdata);
      wait_done();
      chk("R6_R7", $sformatf("vec %0d frame count", i), nfr, v.exp_frames);
      if (v.op == 3'd5 || v.op == 3'd3) begin
        chk("R6", $sformatf("vec %0d wren first", i), fr_op[0], 8'h06);
        chk("R6", $sformatf("vec %0d wren bits", i), fr_bits[0], 8);
        chk("R5", $sformatf("vec %0d main cmd", i), fr_op[1], exp_cmd(v.op));
        chk("R4_R8", $sformatf("vec %0d main bits", i), fr_bits[1], v.exp_bits);
        chk("R7", $sformatf("vec %0d last poll cmd", i), fr_op[4], 8'h05);
        chk("R7", $sformatf("vec %0d device idle", i), wip_left, 0);
      end else begin
        chk("R5", $sformatf("vec %0d cmd", i), fr_op[0], exp_cmd(v.op));
        chk("R4_R8", $sformatf("vec %0d bits", i), fr_bits[0], v.exp_bits);
      end
      if (v.op == 3'd4 || v.op == 3'd5)
        chk("R4", $sformatf("vec %0d address", i), last_addr, v.addr);
      if (v.chk_rd)
        chk((v.op == 3'd2) ? "R9" : "R8", $sformatf("vec %0d rdata", i), rdata, v.exp_rd);
    end

    // R11 request during a write is ignored
    issue(3'd5, 16'h0040, 2'd1, 32'h00003412);
    repeat (40) @(negedge clk);
    chk("R10", "ready low while busy", ready, 1'b0);
    op = 3'd4; addr = 16'h0099; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_done();
    chk("R11", "frames unchanged", nfr, 5);
    chk("R11", "main cmd still write", fr_op[1], 8'h02);
    chk("R11", "data landed", {mem[8'h41], mem[8'h40]}, 16'h3412);

    // R2 and R3 timing
    chk("R2", "sck high min", hi_min, DIV);
    chk("R2", "sck high max", hi_max, DIV);
    chk("R3", "cs high gap", min_gap >= DIV, 1'b1);

    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule